// File: doc/BRIEF.md
# Stop Mode Wake Sequencer

This block runs a full-stop low-power state and the clock restart that follows it. When software writes the stop bit while the core is running, the block drops the system clock enable and both oscillator enables on the next edge. It then waits for an enabled wake event. Events that have their enable cleared are ignored.

A wake is one of two kinds. A reset-type exit asks the chip for a full reset. An interrupt-type exit lets the core resume at the next instruction and then take the pending interrupt. Either way, the restart always begins on the internal RC clock after a short, parameterised settling delay. The clock source select held outside the block is left untouched by stop mode. If it names the high-frequency oscillator, the block powers that oscillator up and counts its warmup in the oscillator's own domain. It hands over to it only once the synchronized done flag arrives. Every change of the clock select happens inside a gap where the system clock enable is low.

The oscillators and brownout logic are modelled as digital inputs. `clk` stands for the RC oscillator and `hf_clk` for the high-frequency oscillator. The block has no streaming interface; all pins are plain level or single-cycle control signals.

Top module: `stopwake_ctrl`

## Requirements
- R1: While `sys_clk_en` is 1, a 1 on `stop_set` at a rising `clk` edge gives, from that edge on, `stop_bit`=1, `sys_clk_en`=0, `rc_osc_en`=0 and `hf_osc_en`=0.
- R2: While stopped, `stop_set` and any event whose enable is 0 have no effect: the block stays stopped and neither request pulses.
- R3: The reset-type wakes are `ext_rst_pin` (never masked) and `por_bor_evt` with `bor_det_en`=1. The interrupt-type wakes are `port_irq` with `port_irq_en`, `can_rx_act` with `can_irq_en`, and `bo_irq` with `bo_irq_en`. When both kinds arrive in the same cycle, the reset-type wake wins.
- R4: On the edge that samples a wake, `stop_bit` clears, `rc_osc_en` rises and `clk_sel_hf` goes to 0 (RC). `sys_clk_en` rises on the RC_WAKE_CYC-th edge after that one. On that same edge exactly one of `reset_req` or `resume_irq_req` pulses high for one cycle, chosen by the wake kind.
- R5: With `src_hf`=1 after an interrupt-type exit, or when it is set while running on RC, `hf_osc_en` goes high at once and the core keeps running on RC. After HF_WARM_CYC `hf_clk` cycles of warmup plus synchronizer latency, `clk_sel_hf` switches to 1 by itself.
- R6: `clk_sel_hf` changes only when `sys_clk_en` is 0 in that cycle and was 0 in the one before. A run-time source switch keeps `sys_clk_en` low for exactly two cycles.
- R7: Clearing `src_hf` while running on the high-frequency clock returns the select to RC through the same two-cycle gap. After that, `hf_osc_en` is 0.
- R8: Clearing `src_hf` during warmup aborts the warmup and no switch takes place. A later request counts the full warmup again from zero.
- R9: After reset the block runs on RC: `sys_clk_en`=1, `rc_osc_en`=1, `clk_sel_hf`=0, `stop_bit`=0, and both requests are 0.
- R10: While running, wake and reset sources have no effect on this block: no request pulses and the clock stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC oscillator clock, sequencer domain |
| hf_clk | input | 1 | High-frequency oscillator clock, warmup domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_set | input | 1 | Software write that sets the stop bit |
| src_hf | input | 1 | Clock source select: 1 = high-frequency, 0 = RC |
| ext_rst_pin | input | 1 | External reset pin asserted |
| por_bor_evt | input | 1 | Power-on / brownout reset event |
| bor_det_en | input | 1 | Brownout reset detection enabled |
| port_irq | input | 1 | External port interrupt condition |
| port_irq_en | input | 1 | Port interrupt enable |
| can_rx_act | input | 1 | Activity on the CAN receive line |
| can_irq_en | input | 1 | CAN activity interrupt enable |
| bo_irq | input | 1 | Supply brownout interrupt condition |
| bo_irq_en | input | 1 | Brownout interrupt enable |
| sys_clk_en | output | 1 | System clock enable |
| clk_sel_hf | output | 1 | Clock mux select: 1 = high-frequency |
| rc_osc_en | output | 1 | RC oscillator enable |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| stop_bit | output | 1 | Stop bit as seen by software |
| reset_req | output | 1 | One-cycle request for a full reset |
| resume_irq_req | output | 1 | One-cycle request to resume and take the interrupt |

## Verification
The assertions check, on every cycle, the properties that do not depend on timing across domains. Stop entry must shut off all enables. The select may only move inside a clock-off gap. The two exit requests never overlap, and a request appears only as the clock restarts on RC. The bench scenarios cover the rest: the sorting of random mixes of masked and enabled sources into wake kinds, the exact settling delay, and the warmup window across the two clock domains. They also show that an aborted warmup never switches the clock and that a new request restarts the count.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

  typedef enum logic [2:0] {
    SW_RUN     = 3'd0,
    SW_STOP    = 3'd1,
    SW_WAKE    = 3'd2,
    SW_GAP_OFF = 3'd3,
    SW_GAP_SEL = 3'd4
  } sw_state_e;

  typedef enum logic [1:0] {
    EXIT_NONE  = 2'd0,
    EXIT_RESET = 2'd1,
    EXIT_IRQ   = 2'd2
  } exit_kind_e;

  typedef struct packed {
    logic rst_pin;
    logic por_bor;
    logic bor_en;
    logic port_irq;
    logic port_en;
    logic can_act;
    logic can_en;
    logic bo_irq;
    logic bo_en;
  } wake_in_t;

endpackage

// File: rtl/stopwake_sync.sv
module stopwake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  // Plain flop chain; STAGES must be at least 2.
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stopwake_wake_detect.sv
module stopwake_wake_detect
  import stopwake_pkg::*;
(
  input  wake_in_t   wake_in,
  output exit_kind_e kind
);
  localparam int NUM_IRQ = 3;

  logic [NUM_IRQ-1:0] irq_src;
  logic [NUM_IRQ-1:0] irq_en;
  logic [NUM_IRQ-1:0] irq_hit;
  logic               rst_hit;

  assign irq_src = {wake_in.port_irq, wake_in.can_act, wake_in.bo_irq};
  assign irq_en  = {wake_in.port_en,  wake_in.can_en,  wake_in.bo_en};

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irq_hit[i] = irq_src[i] & irq_en[i];
  end

  // The reset pin cannot be masked; power-on/brownout needs detection enabled.
  assign rst_hit = wake_in.rst_pin | (wake_in.por_bor & wake_in.bor_en);

  always_comb begin
    if (rst_hit)       kind = EXIT_RESET;
    else if (|irq_hit) kind = EXIT_IRQ;
    else               kind = EXIT_NONE;
  end
endmodule

// File: rtl/stopwake_warmup.sv
module stopwake_warmup #(
  parameter int HF_WARM_CYC = 4096
) (
  input  logic hf_clk,
  input  logic rst_n,
  input  logic req,
  output logic done
);
  localparam int CNT_W = $clog2(HF_WARM_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HF_WARM_CYC);

  logic [CNT_W-1:0] cnt;

  // The count restarts whenever the request drops, so a stale count never survives.
  always_ff @(posedge hf_clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!req)         cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/stopwake_seq.sv
module stopwake_seq
  import stopwake_pkg::*;
#(
  parameter int RC_WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_set,
  input  logic       src_hf,
  input  exit_kind_e wake_kind,
  input  logic       warm_done,
  output logic       warm_req,
  output logic       sys_clk_en,
  output logic       clk_sel_hf,
  output logic       rc_osc_en,
  output logic       hf_osc_en,
  output logic       stop_bit,
  output logic       reset_req,
  output logic       resume_irq_req
);
  localparam int WCNT_W = $clog2(RC_WAKE_CYC + 1);
  localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(RC_WAKE_CYC - 1);

  sw_state_e         state;
  exit_kind_e        kind_q;
  logic [WCNT_W-1:0] wcnt;
  logic              sel_hf;
  logic              warm_ok;
  logic              done_prev;
  logic              rst_pulse;
  logic              irq_pulse;
  logic              want_hf;
  logic              want_rc;

  assign warm_req = (state == SW_RUN) & src_hf & ~sel_hf;
  assign want_hf  = warm_ok & src_hf & ~sel_hf;
  assign want_rc  = sel_hf & ~src_hf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SW_RUN;
      kind_q    <= EXIT_NONE;
      wcnt      <= '0;
      sel_hf    <= 1'b0;
      warm_ok   <= 1'b0;
      done_prev <= 1'b0;
      rst_pulse <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      irq_pulse <= 1'b0;
      done_prev <= warm_done;
      // Accept only a fresh rising done while the request is held.
      if (!warm_req)                  warm_ok <= 1'b0;
      else if (warm_done && !done_prev) warm_ok <= 1'b1;

      unique case (state)
        SW_RUN: begin
          if (stop_set)                state <= SW_STOP;
          else if (want_hf || want_rc) state <= SW_GAP_OFF;
        end
        SW_STOP: begin
          if (wake_kind != EXIT_NONE) begin
            kind_q <= wake_kind;
            sel_hf <= 1'b0;   // restart always on RC; clock already gated
            wcnt   <= '0;
            state  <= SW_WAKE;
          end
        end
        SW_WAKE: begin
          if (wcnt == WLAST) begin
            state     <= SW_RUN;
            rst_pulse <= (kind_q == EXIT_RESET);
            irq_pulse <= (kind_q == EXIT_IRQ);
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        SW_GAP_OFF: begin
          sel_hf <= ~sel_hf;  // enable has been low for a full cycle
          state  <= SW_GAP_SEL;
        end
        SW_GAP_SEL: state <= SW_RUN;
        default:    state <= SW_RUN;
      endcase
    end
  end

  assign sys_clk_en     = (state == SW_RUN);
  assign stop_bit       = (state == SW_STOP);
  assign rc_osc_en      = (state != SW_STOP);
  assign hf_osc_en      = ((state == SW_RUN) || (state == SW_GAP_OFF) || (state == SW_GAP_SEL))
                          && (src_hf || sel_hf);
  assign clk_sel_hf     = sel_hf;
  assign reset_req      = rst_pulse;
  assign resume_irq_req = irq_pulse;
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import stopwake_pkg::*;
#(
  parameter int RC_WAKE_CYC = 4,
  parameter int HF_WARM_CYC = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic hf_clk,
  input  logic rst_n,
  input  logic stop_set,
  input  logic src_hf,
  input  logic ext_rst_pin,
  input  logic por_bor_evt,
  input  logic bor_det_en,
  input  logic port_irq,
  input  logic port_irq_en,
  input  logic can_rx_act,
  input  logic can_irq_en,
  input  logic bo_irq,
  input  logic bo_irq_en,
  output logic sys_clk_en,
  output logic clk_sel_hf,
  output logic rc_osc_en,
  output logic hf_osc_en,
  output logic stop_bit,
  output logic reset_req,
  output logic resume_irq_req
);
  wake_in_t   wake_in;
  exit_kind_e wake_kind;
  logic       warm_req;
  logic       warm_req_hf;
  logic       warm_done_hf;
  logic       warm_done_rc;

  assign wake_in = '{rst_pin: ext_rst_pin, por_bor: por_bor_evt, bor_en: bor_det_en,
                     port_irq: port_irq, port_en: port_irq_en,
                     can_act: can_rx_act, can_en: can_irq_en,
                     bo_irq: bo_irq, bo_en: bo_irq_en};

  stopwake_wake_detect u_detect (
    .wake_in (wake_in),
    .kind    (wake_kind)
  );

  stopwake_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (hf_clk),
    .rst_n (rst_n),
    .d     (warm_req),
    .q     (warm_req_hf)
  );

  stopwake_warmup #(.HF_WARM_CYC(HF_WARM_CYC)) u_warm (
    .hf_clk (hf_clk),
    .rst_n  (rst_n),
    .req    (warm_req_hf),
    .done   (warm_done_hf)
  );

  stopwake_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (warm_done_hf),
    .q     (warm_done_rc)
  );

  stopwake_seq #(.RC_WAKE_CYC(RC_WAKE_CYC)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_set       (stop_set),
    .src_hf         (src_hf),
    .wake_kind      (wake_kind),
    .warm_done      (warm_done_rc),
    .warm_req       (warm_req),
    .sys_clk_en     (sys_clk_en),
    .clk_sel_hf     (clk_sel_hf),
    .rc_osc_en      (rc_osc_en),
    .hf_osc_en      (hf_osc_en),
    .stop_bit       (stop_bit),
    .reset_req      (reset_req),
    .resume_irq_req (resume_irq_req)
  );
endmodule

// File: rtl/stopwake_ctrl_chk.sv
module stopwake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_set,
  input logic sys_clk_en,
  input logic clk_sel_hf,
  input logic rc_osc_en,
  input logic hf_osc_en,
  input logic stop_bit,
  input logic reset_req,
  input logic resume_irq_req
);
  assert_stop_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && stop_set) |=> (stop_bit && !rc_osc_en && !hf_osc_en));

  assert_stopped_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit |-> (!sys_clk_en && !rc_osc_en && !hf_osc_en));

  assert_one_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req && resume_irq_req));

  assert_exit_on_rc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || resume_irq_req) |-> (sys_clk_en && !clk_sel_hf && $past(!sys_clk_en)));

  assert_wake_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_bit) |-> (!clk_sel_hf && rc_osc_en && !sys_clk_en));

  assert_sel_in_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel_hf) |-> (!sys_clk_en && $past(!sys_clk_en)));

  assert_hf_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_hf && sys_clk_en) |-> hf_osc_en);
endmodule

bind stopwake_ctrl stopwake_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stop_set       (stop_set),
  .sys_clk_en     (sys_clk_en),
  .clk_sel_hf     (clk_sel_hf),
  .rc_osc_en      (rc_osc_en),
  .hf_osc_en      (hf_osc_en),
  .stop_bit       (stop_bit),
  .reset_req      (reset_req),
  .resume_irq_req (resume_irq_req)
);

// File: tb/stopwake_ctrl_test.sv
module stopwake_ctrl_test;
  localparam int CLK_PERIOD  = 10;
  localparam int HF_PERIOD   = 6;
  localparam int RC_WAKE     = 4;
  localparam int HF_WARM     = 64;
  localparam int WARM_LO     = HF_WARM * HF_PERIOD / CLK_PERIOD;
  localparam int WARM_HI     = WARM_LO + 18;

  logic clk = 0, hf_clk = 0, rst_n = 0;
  logic stop_set = 0, src_hf = 0;
  logic ext_rst_pin = 0, por_bor_evt = 0, bor_det_en = 0;
  logic port_irq = 0, port_irq_en = 0, can_rx_act = 0, can_irq_en = 0;
  logic bo_irq = 0, bo_irq_en = 0;
  logic sys_clk_en, clk_sel_hf, rc_osc_en, hf_osc_en, stop_bit, reset_req, resume_irq_req;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(HF_PERIOD/2) hf_clk = ~hf_clk;

  stopwake_ctrl #(.RC_WAKE_CYC(RC_WAKE), .HF_WARM_CYC(HF_WARM), .SYNC_STAGES(2)) uut (
    .clk(clk), .hf_clk(hf_clk), .rst_n(rst_n), .stop_set(stop_set), .src_hf(src_hf),
    .ext_rst_pin(ext_rst_pin), .por_bor_evt(por_bor_evt), .bor_det_en(bor_det_en),
    .port_irq(port_irq), .port_irq_en(port_irq_en), .can_rx_act(can_rx_act),
    .can_irq_en(can_irq_en), .bo_irq(bo_irq), .bo_irq_en(bo_irq_en),
    .sys_clk_en(sys_clk_en), .clk_sel_hf(clk_sel_hf), .rc_osc_en(rc_osc_en),
    .hf_osc_en(hf_osc_en), .stop_bit(stop_bit), .reset_req(reset_req),
    .resume_irq_req(resume_irq_req));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // vector bits: 8 rst_pin,7 por,6 bor_en,5 port,4 port_en,3 can,2 can_en,1 bo,0 bo_en
  // returns 0 none, 1 reset-type, 2 interrupt-type (R3)
  function automatic int classify(logic [8:0] v);
    if (v[8] || (v[7] && v[6])) return 1;
    if ((v[5] && v[4]) || (v[3] && v[2]) || (v[1] && v[0])) return 2;
    return 0;
  endfunction

  task automatic drive(logic [8:0] v);
    {ext_rst_pin, por_bor_evt, bor_det_en, port_irq, port_irq_en,
     can_rx_act, can_irq_en, bo_irq, bo_irq_en} = v;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_set = 1;
    @(negedge clk) stop_set = 0;
    chk("R1 stop_bit", stop_bit, 1);
    chk("R1 sys_clk_en", sys_clk_en, 0);
    chk("R1 osc off", rc_osc_en | hf_osc_en, 0);
  endtask

  task automatic apply_wake(logic [8:0] v);
    int kind;
    kind = classify(v);
    @(negedge clk) drive(v);
    @(negedge clk) drive('0);
    if (kind == 0) begin
      chk("R2 still stopped", stop_bit, 1);
      chk("R2 no request", reset_req | resume_irq_req, 0);
      return;
    end
    chk("R4 stop_bit cleared", stop_bit, 0);
    chk("R4 rc on, clock held", {rc_osc_en, sys_clk_en, clk_sel_hf}, 3'b100);
    for (int i = 1; i < RC_WAKE; i++) begin
      @(negedge clk);
      chk("R4 settling", {sys_clk_en, reset_req, resume_irq_req}, 0);
    end
    @(negedge clk);
    chk("R4 clock restarted", sys_clk_en, 1);
    chk("R3 reset_req", reset_req, kind == 1);
    chk("R3 resume_irq_req", resume_irq_req, kind == 2);
    @(negedge clk);
    chk("R4 single pulse", reset_req | resume_irq_req, 0);
  endtask

  // Waits for clk_sel_hf to reach exp; checks the clock-off gap (R6).
  task automatic wait_sel(logic exp, output int n);
    logic prev_en;
    n = 0;
    prev_en = sys_clk_en;
    while (clk_sel_hf !== exp && n < 400) begin
      prev_en = sys_clk_en;
      @(negedge clk);
      n++;
    end
    chk("R6 gap before", prev_en, 0);
    chk("R6 gap at change", sys_clk_en, 0);
    @(negedge clk);
    chk("R6 clock back", sys_clk_en, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [8:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 enables", {sys_clk_en, rc_osc_en, hf_osc_en}, 3'b110);
    chk("R9 sel/stop", {clk_sel_hf, stop_bit}, 0);
    chk("R9 requests", reset_req | resume_irq_req, 0);

    // R10: sources while running do nothing
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) drive(9'($urandom));
      @(negedge clk);
      chk("R10 running unaffected", {sys_clk_en, stop_bit, reset_req, resume_irq_req}, 4'b1000);
    end
    drive('0);

    // Directed: simultaneous wake kinds, reset wins (R3)
    do_stop();
    apply_wake(9'b1_00_11_00_00);
    // Directed: stop_set while stopped is ignored (R2)
    do_stop();
    @(negedge clk) stop_set = 1;
    @(negedge clk) stop_set = 0;
    chk("R2 stop_set ignored", stop_bit, 1);
    // por without detection enabled is masked, then CAN wakes (R2, R3)
    apply_wake(9'b0_10_00_00_00);
    apply_wake(9'b0_00_00_11_00);

    // Random mixes of masked and enabled sources
    for (int it = 0; it < 40; it++) begin
      do_stop();
      repeat ($urandom_range(1, 3)) begin
        v = 9'($urandom);
        v[8] = 0; v[6] = 0; v[4] = 0; v[2] = 0; v[0] = 0;
        apply_wake(v);
      end
      do begin v = 9'($urandom); end while (classify(v) == 0);
      apply_wake(v);
    end

    // R5: select high-frequency source while on RC
    @(negedge clk) src_hf = 1;
    @(negedge clk);
    chk("R5 hf osc on", hf_osc_en, 1);
    chk("R5 still on RC", clk_sel_hf, 0);
    wait_sel(1, n);
    chk("R5 switched", clk_sel_hf, 1);
    chk("R5 warmup long enough", n >= WARM_LO, 1);
    chk("R5 warmup bounded", n <= WARM_HI, 1);

    // Stop from HF, interrupt wake: restart on RC, then automatic switch (R4, R5)
    do_stop();
    apply_wake(9'b0_00_11_00_00);
    chk("R4 resumed on RC", clk_sel_hf, 0);
    chk("R5 hf osc on after wake", hf_osc_en, 1);
    wait_sel(1, n);
    chk("R5 switched after wake", clk_sel_hf, 1);
    chk("R5 rewarm long enough", n >= WARM_LO - 1, 1);

    // R7: drop src_hf while on HF
    @(negedge clk) src_hf = 0;
    wait_sel(0, n);
    chk("R7 back on RC quickly", n <= 4, 1);
    chk("R7 hf osc off", hf_osc_en, 0);

    // R8: abort warmup, then full restart
    @(negedge clk) src_hf = 1;
    repeat (WARM_LO / 2) @(negedge clk);
    src_hf = 0;
    n = 0;
    repeat (WARM_HI + 10) begin
      @(negedge clk);
      if (clk_sel_hf) n++;
    end
    chk("R8 aborted no switch", n, 0);
    @(negedge clk) src_hf = 1;
    wait_sel(1, n);
    chk("R8 full count again", n >= WARM_LO, 1);

    // Reset-type wake with HF selected still restarts on RC (R4)
    do_stop();
    apply_wake(9'b0_11_00_00_00);
    @(negedge clk) src_hf = 0;
    repeat (5) @(negedge clk);
    chk("R7 settled on RC", clk_sel_hf, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule